// File: doc/BRIEF.md
# Burst Row Refresh Controller

This block keeps a dynamic RAM alive by sweeping every row address in one burst of row-strobe-only cycles. An interval counter measures the refresh period in clock cycles. When it runs out, the block raises a request towards the access sequencer. It waits until that sequencer reports idle, and then it takes ownership of the shared row/column strobes and the address bus. It walks the rows from zero upward, holding the column strobe inactive for the whole sweep, and then hands the bus back.

The outputs go to an external multiplexer. `ref_own` selects this block's strobes and address in place of the sequencer's. `ref_busy` marks the sweep itself. The sequencer must not start an access while `ref_req` or `ref_own` is high. The interval counter reloads at the grant, so the spacing between sweeps depends only on when each sweep starts.

Top module: `drf_refresh_engine`

## Requirements
- R1: While reset is held, `ref_ras_n` and `ref_cas_n` are 1, `ref_own`, `ref_busy` and `ref_req` are 0, and `ref_addr` is 0.
- R2: After reset is released, `ref_req` first reads 1 after clock edge INTERVAL-1 and reads 0 after edge INTERVAL-2. Edges are counted from the first edge after release.
- R3: A grant happens at an edge where `ref_req` and `seq_idle` are both 1. `ref_own` and `ref_busy` rise after that edge. While `seq_idle` is 0, `ref_own` stays 0 and `ref_req` stays 1.
- R4: `ref_cas_n` is 1 in every cycle in which `ref_own` is 1.
- R5: The rows are visited as 0, 1, …, NUM_ROWS-1. For each row, `ref_ras_n` is 0 for RAS_LOW_CYC cycles and then 1 for RAS_HIGH_CYC cycles. `ref_addr` carries the row number, zero-extended, and it is stable while `ref_ras_n` is 0.
- R6: The first cycle after a grant is a setup cycle. In it `ref_own` is 1, `ref_ras_n` is 1 and `ref_addr` is 0. The first low phase of `ref_ras_n` follows it.
- R7: `ref_busy` falls in the cycle after the last high phase of `ref_ras_n`. In that cycle `ref_own` is still 1 and `ref_addr` still reads NUM_ROWS-1. `ref_own` falls one cycle later, and then `ref_addr` returns to 0.
- R8: The interval counter reloads at the grant. The next `ref_req` reads 1 after edge G+INTERVAL-1, where G is the grant edge, however long the previous grant was delayed. If `seq_idle` is already 1, the next grant is at edge G+INTERVAL.
- R9: `ref_req` is 0 in every cycle in which `ref_own` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_idle | input | 1 | Access sequencer has no access in flight |
| ref_req | output | 1 | Refresh is due and waiting for the sequencer |
| ref_own | output | 1 | Multiplexer select: bus belongs to this block |
| ref_busy | output | 1 | Row sweep in progress |
| ref_ras_n | output | 1 | Row strobe, active low |
| ref_cas_n | output | 1 | Column strobe, active low (held high) |
| ref_addr | output | ADDR_W | Row address, zero-extended |

## Verification
Two things can fall in the same cycle: the interval counter expiring and the sequencer being idle. In that case the request and the grant share one edge. To provoke this, the bench holds `seq_idle` high from the previous grant onward. It then expects `ref_req` high with `ref_own` low after edge G+INTERVAL-1, and `ref_own` high one edge later. The opposite ordering is also covered. In a delayed grant, the bench holds `seq_idle` low past expiry. It checks that ownership is withheld, and that the next period is measured from the late grant and not from the expiry.

// File: rtl/drf_pkg.sv
package drf_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_LOW   = 3'd2,
      ST_HIGH  = 3'd3,
      ST_REL   = 3'd4
   } drf_state_e;

endpackage

// File: rtl/drf_interval_timer.sv
module drf_interval_timer #(
   parameter int unsigned INTERVAL = 800000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic reload,
   output logic expired
);
   localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
   localparam logic [CW-1:0] TOP = CW'(INTERVAL - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= TOP;
      else if (reload)        cnt_q <= TOP;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/drf_row_stepper.sv
module drf_row_stepper #(
   parameter int unsigned NUM_ROWS = 256
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clear,
   input  logic                         step,
   output logic [$clog2(NUM_ROWS)-1:0]  row,
   output logic                         last
);
   localparam int unsigned RW = $clog2(NUM_ROWS);
   localparam logic [RW-1:0] FINAL = RW'(NUM_ROWS - 1);

   logic [RW-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      row_q <= '0;
      else if (clear)  row_q <= '0;
      else if (step)   row_q <= row_q + 1'b1;
   end

   assign row  = row_q;
   assign last = (row_q == FINAL);
endmodule

// File: rtl/drf_phase_timer.sv
module drf_phase_timer #(
   parameter int unsigned LOW_CYC  = 2,
   parameter int unsigned HIGH_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_low,
   input  logic load_high,
   output logic done
);
   localparam int unsigned MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
   localparam int unsigned PW   = (MAXC > 1) ? $clog2(MAXC) : 1;

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n)          ph_q <= '0;
      else if (load_low)   ph_q <= PW'(LOW_CYC - 1);
      else if (load_high)  ph_q <= PW'(HIGH_CYC - 1);
      else if (ph_q != '0) ph_q <= ph_q - 1'b1;
   end

   assign done = (ph_q == '0);
endmodule

// File: rtl/drf_refresh_engine.sv
module drf_refresh_engine
   import drf_pkg::*;
#(
   parameter int unsigned INTERVAL     = 800000,
   parameter int unsigned NUM_ROWS     = 256,
   parameter int unsigned ADDR_W       = 10,
   parameter int unsigned RAS_LOW_CYC  = 2,
   parameter int unsigned RAS_HIGH_CYC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seq_idle,
   output logic              ref_req,
   output logic              ref_own,
   output logic              ref_busy,
   output logic              ref_ras_n,
   output logic              ref_cas_n,
   output logic [ADDR_W-1:0] ref_addr
);
   localparam int unsigned ROW_W     = $clog2(NUM_ROWS);
   localparam int unsigned BURST_LEN = 2 + NUM_ROWS * (RAS_LOW_CYC + RAS_HIGH_CYC);

   if (ADDR_W < ROW_W) begin : g_bad_addr
      $error("ADDR_W narrower than the row index");
   end
   if (RAS_LOW_CYC < 1 || RAS_HIGH_CYC < 1) begin : g_bad_phase
      $error("strobe phases need at least one cycle");
   end
   if (INTERVAL <= BURST_LEN) begin : g_bad_interval
      $error("INTERVAL must exceed one full sweep");
   end
   if (NUM_ROWS < 2 || (1 << ROW_W) != NUM_ROWS) begin : g_bad_rows
      $error("NUM_ROWS must be a power of two, at least 2");
   end

   drf_state_e state_q, state_d;

   logic             expired, grant;
   logic             row_clear, row_step, row_last;
   logic [ROW_W-1:0] row;
   logic             ph_load_low, ph_load_high, ph_done;

   drf_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .reload  (grant),
      .expired (expired)
   );

   drf_row_stepper #(.NUM_ROWS(NUM_ROWS)) u_rows (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (row_clear),
      .step  (row_step),
      .row   (row),
      .last  (row_last)
   );

   drf_phase_timer #(.LOW_CYC(RAS_LOW_CYC), .HIGH_CYC(RAS_HIGH_CYC)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_low  (ph_load_low),
      .load_high (ph_load_high),
      .done      (ph_done)
   );

   always_comb begin
      state_d      = state_q;
      grant        = 1'b0;
      row_clear    = 1'b0;
      row_step     = 1'b0;
      ph_load_low  = 1'b0;
      ph_load_high = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (expired && seq_idle) begin
               grant     = 1'b1;
               row_clear = 1'b1;
               state_d   = ST_SETUP;
            end
         end
         ST_SETUP: begin
            ph_load_low = 1'b1;
            state_d     = ST_LOW;
         end
         ST_LOW: begin
            if (ph_done) begin
               ph_load_high = 1'b1;
               state_d      = ST_HIGH;
            end
         end
         ST_HIGH: begin
            if (ph_done) begin
               if (row_last) begin
                  state_d = ST_REL;
               end else begin
                  row_step    = 1'b1;
                  ph_load_low = 1'b1;
                  state_d     = ST_LOW;
               end
            end
         end
         ST_REL:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign ref_req   = (state_q == ST_IDLE) && expired;
   assign ref_own   = (state_q != ST_IDLE);
   assign ref_busy  = ref_own && (state_q != ST_REL);
   assign ref_ras_n = (state_q != ST_LOW);
   assign ref_cas_n = 1'b1;

   if (ADDR_W > ROW_W) begin : g_addr_pad
      assign ref_addr = ref_own ? {{(ADDR_W - ROW_W){1'b0}}, row} : '0;
   end else begin : g_addr_exact
      assign ref_addr = ref_own ? row : '0;
   end
endmodule

// File: rtl/drf_refresh_checker.sv
module drf_refresh_checker #(
   parameter int unsigned INTERVAL = 800000,
   parameter int unsigned NUM_ROWS = 256,
   parameter int unsigned ADDR_W   = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seq_idle,
   input logic              ref_req,
   input logic              ref_own,
   input logic              ref_busy,
   input logic              ref_ras_n,
   input logic              ref_cas_n,
   input logic [ADDR_W-1:0] ref_addr
);
   logic        own_d, seen;
   logic [31:0] gap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         own_d <= 1'b0;
         seen  <= 1'b0;
         gap   <= '0;
      end else begin
         own_d <= ref_own;
         if (ref_own && !own_d) begin
            gap  <= 32'd1;
            seen <= 1'b1;
         end else if (gap != 32'hFFFF_FFFF) begin
            gap <= gap + 32'd1;
         end
      end
   end

   assert_grant_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ref_own) |-> ($past(seq_idle) && $past(ref_req)));

   assert_cas_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ref_own |-> ref_cas_n);

   assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ref_ras_n && $past(!ref_ras_n)) |-> $stable(ref_addr));

   assert_ras_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_ras_n |-> ref_busy);

   assert_last_row_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ref_busy) |-> (ref_own && ref_addr == ADDR_W'(NUM_ROWS - 1)));

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_own && !ref_busy) |=> !ref_own);

   assert_period_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_own && !own_d && seen) |-> (gap >= INTERVAL));

   assert_req_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ref_own |-> !ref_req);
endmodule

bind drf_refresh_engine drf_refresh_checker #(
   .INTERVAL (INTERVAL),
   .NUM_ROWS (NUM_ROWS),
   .ADDR_W   (ADDR_W)
) u_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .seq_idle  (seq_idle),
   .ref_req   (ref_req),
   .ref_own   (ref_own),
   .ref_busy  (ref_busy),
   .ref_ras_n (ref_ras_n),
   .ref_cas_n (ref_cas_n),
   .ref_addr  (ref_addr)
);

// File: tb/tb_drf_refresh_engine.sv
`timescale 1ns/1ps
module tb_drf_refresh_engine;
   localparam int unsigned INTERVAL = 1500;
   localparam int unsigned ROWS     = 256;
   localparam int unsigned AW       = 10;
   localparam int unsigned LO       = 2;
   localparam int unsigned HI       = 2;
   localparam int unsigned SWEEP    = 1 + ROWS * (LO + HI);
   localparam int          NV       = 11;
   // columns: offset after grant edge, ras_n, addr, busy, own
   localparam int VEC [NV][5] = '{
      '{0,    1, 0,   1, 1},
      '{1,    0, 0,   1, 1},
      '{2,    0, 0,   1, 1},
      '{3,    1, 0,   1, 1},
      '{4,    1, 0,   1, 1},
      '{5,    0, 1,   1, 1},
      '{513,  0, 128, 1, 1},
      '{1021, 0, 255, 1, 1},
      '{1024, 1, 255, 1, 1},
      '{1025, 1, 255, 0, 1},
      '{1026, 1, 0,   0, 0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          seq_idle = 1'b0;
   logic          ref_req, ref_own, ref_busy, ref_ras_n, ref_cas_n;
   logic [AW-1:0] ref_addr;

   int checks = 0;
   int fails  = 0;
   int edges  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) edges <= 0;
      else        edges <= edges + 1;
   end

   drf_refresh_engine #(
      .INTERVAL(INTERVAL), .NUM_ROWS(ROWS), .ADDR_W(AW),
      .RAS_LOW_CYC(LO), .RAS_HIGH_CYC(HI)
   ) dut (
      .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle),
      .ref_req(ref_req), .ref_own(ref_own), .ref_busy(ref_busy),
      .ref_ras_n(ref_ras_n), .ref_cas_n(ref_cas_n), .ref_addr(ref_addr)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, act, exp, edges);
      end
   endtask

   task automatic to_edge(input int n);
      while (edges < n) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      #(5ns * 100000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      int g1, g2, g3, bad;
      repeat (4) @(negedge clk);
      // R1 reset state
      chk("R1 ras_n", ref_ras_n, 1);
      chk("R1 cas_n", ref_cas_n, 1);
      chk("R1 own",   ref_own,   0);
      chk("R1 busy",  ref_busy,  0);
      chk("R1 req",   ref_req,   0);
      chk("R1 addr",  ref_addr,  0);
      rst_n = 1'b1;

      // R2 first request timing
      to_edge(INTERVAL - 2);
      chk("R2 req early", ref_req, 0);
      to_edge(INTERVAL - 1);
      chk("R2 req due", ref_req, 1);

      // R3 held off while sequencer busy
      to_edge(INTERVAL + 19);
      chk("R3 own withheld", ref_own, 0);
      chk("R3 req held", ref_req, 1);
      seq_idle = 1'b1;
      g1 = edges + 1;

      // R5 R6 R7 table walk
      for (int i = 0; i < NV; i++) begin
         to_edge(g1 + VEC[i][0]);
         chk($sformatf("R5/R6/R7 ras_n t=%0d", VEC[i][0]), ref_ras_n, VEC[i][1]);
         chk($sformatf("R5/R6/R7 addr t=%0d",  VEC[i][0]), ref_addr,  VEC[i][2]);
         chk($sformatf("R7 busy t=%0d",        VEC[i][0]), ref_busy,  VEC[i][3]);
         chk($sformatf("R3/R7 own t=%0d",      VEC[i][0]), ref_own,   VEC[i][4]);
      end

      // R8 delayed grant: timer measured from late grant
      seq_idle = 1'b0;
      to_edge(g1 + INTERVAL + 49);
      chk("R3 own withheld again", ref_own, 0);
      seq_idle = 1'b1;
      g2 = edges + 1;
      to_edge(g2);
      chk("R3 own after late grant", ref_own, 1);
      to_edge(g2 + INTERVAL - 2);
      chk("R8 req not yet", ref_req, 0);
      to_edge(g2 + INTERVAL - 1);
      chk("R8 req from grant", ref_req, 1);
      chk("R8 own before coincident grant", ref_own, 0);
      g3 = g2 + INTERVAL;
      to_edge(g3);
      chk("R8 coincident grant own", ref_own, 1);

      // R4 R5 R9 full sweep against model
      bad = 0;
      for (int t = 0; t <= SWEEP + 1; t++) begin
         int e_ras, e_addr, e_own;
         to_edge(g3 + t);
         e_own = (t <= SWEEP) ? 1 : 0;
         if (t == 0 || t == SWEEP) begin
            e_ras = 1; e_addr = (t == 0) ? 0 : ROWS - 1;
         end else if (t > SWEEP) begin
            e_ras = 1; e_addr = 0;
         end else begin
            e_ras  = (((t - 1) % (LO + HI)) < LO) ? 0 : 1;
            e_addr = (t - 1) / (LO + HI);
         end
         if (bad == 0 && (ref_ras_n != e_ras || ref_addr != e_addr || ref_own != e_own)) begin
            bad = 1;
            $display("FAIL R5 sweep t=%0d: actual ras_n=%0d addr=%0d own=%0d expected %0d %0d %0d",
                     t, ref_ras_n, ref_addr, ref_own, e_ras, e_addr, e_own);
         end
         if (ref_own && !ref_cas_n && bad < 2) begin
            bad = 2;
            $display("FAIL R4 t=%0d: actual cas_n=0 expected 1", t);
         end
         if (ref_own && ref_req && bad < 3) begin
            bad = 3;
            $display("FAIL R9 t=%0d: actual req=1 expected 0", t);
         end
      end
      checks++;
      if (bad != 0) fails++;

      done = 1'b1;
      summary();
      $finish;
   end
endmodule